// File: doc/BRIEF.md
# Protected Flash Page Request Controller

This block is the command front end of a memory-mapped controller for a serial configuration flash. Software selects a flash page through a page register, then writes a command byte that can carry two region-unlock bits, a transfer-size bit and up to three request bits (erase, write, read). The controller checks the chosen request against the page number. It then starts an external flash engine through a start/done handshake, giving it an operation code, a 24-bit byte address and a transfer length. If the check fails, it sets an error flag and does not start the engine.

The low pages of the flash are split into two guarded regions. Configuration pages 0x0000 to 0x02FF need the configuration unlock bit for a write or an erase. Program pages 0x0300 to 0x05FF need the program unlock bit. An erase acts on a 16-page sector and must name a page that starts a sector. Both unlock bits drop after every operation, whether it completes or is refused, so software must unlock again before each guarded transfer. A read of the command register returns only the busy and error flags.

Top module: `flash_req_ctrl`

## Requirements
- R1: Command byte bits are [7] program unlock, [6] configuration unlock, [5] packed length, [4] erase, [3] write, [2] read. Reading with rd_sel=1 returns busy in bit 0 and error in bit 1, with every other bit zero. Reading with rd_sel=0 returns the page register.
- R2: eng_addr equals the page register followed by eight zero bits. eng_len512 equals the packed-length bit of the accepted command (1 means 512 bytes, 0 means 256 bytes).
- R3: eng_op codes are 1 for read, 2 for write and 3 for erase. When several request bits arrive together, erase beats write and write beats read.
- R4: A read request is accepted at any page, with or without unlock bits.
- R5: A write or erase to pages 0x0000 to 0x02FF is accepted only if the configuration unlock bit is set. The program unlock bit does not count here.
- R6: A write or erase to pages 0x0300 to 0x05FF is accepted only if the program unlock bit is set. A write above 0x05FF needs no unlock bit.
- R7: An erase is refused when the page number is not a multiple of 16.
- R8: A refused request produces no eng_start. From the next cycle, error reads 1 and busy reads 0.
- R9: An accepted request raises eng_start for exactly one cycle, starting in the cycle after the command write. Busy then holds until eng_done, and error clears.
- R10: An unlock bit written without a request is kept for the next request. An unlock bit written together with a request applies to that request. Both unlock bits clear after a refusal or after eng_done.
- R11: While busy, writes to either register are ignored, including a command write in the same cycle as eng_done. eng_done has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 page, 1 command |
| wr_data | input | 16 | Write data (command uses bits 7:0) |
| rd_sel | input | 1 | Read source: 0 page, 1 status |
| rd_data | output | 16 | Read data |
| eng_start | output | 1 | One-cycle start pulse to the flash engine |
| eng_op | output | 2 | Operation code (1 read, 2 write, 3 erase) |
| eng_addr | output | 24 | Flash byte address |
| eng_len512 | output | 1 | Transfer length: 1 means 512 bytes, 0 means 256 bytes |
| eng_done | input | 1 | Engine completion pulse |

## Verification
Two things can happen in the same cycle: the engine finishes (eng_done) and software writes a new command. The bench drives both at the same edge. It then checks that busy has cleared, that no new start pulse appears in either of the next two cycles, and that the status reads zero. A second overlap is a refused request in the same write as its unlock bits. The bench shows that the refusal itself clears the unlock bits, because a later request to the other guarded region is also refused.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } fop_e;

  localparam int B_SECP = 7;
  localparam int B_SECC = 6;
  localparam int B_PACK = 5;
  localparam int B_ERS  = 4;
  localparam int B_WR   = 3;
  localparam int B_RD   = 2;
endpackage

// File: rtl/fpr_page_reg.sv
module fpr_page_reg #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] page_q
);
  logic [PW-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (load) page_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end
endmodule

// File: rtl/fpr_guard.sv
module fpr_guard
  import fpr_pkg::*;
#(
  parameter int          PW           = 16,
  parameter int unsigned CFG_LAST     = 32'h02FF,
  parameter int unsigned PRG_LAST     = 32'h05FF,
  parameter int          SECTOR_PAGES = 16
) (
  input  logic [PW-1:0] page,
  input  logic          req_ers,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic          sec_p,
  input  logic          sec_c,
  output fop_e          op,
  output logic          legal
);
  localparam int            AB    = $clog2(SECTOR_PAGES);
  localparam logic [PW-1:0] CFG_L = PW'(CFG_LAST);
  localparam logic [PW-1:0] PRG_L = PW'(PRG_LAST);

  logic in_cfg, in_prg, prot_ok, aligned;

  always_comb begin
    // erase over write over read
    if (req_ers)     op = OP_ERASE;
    else if (req_wr) op = OP_WRITE;
    else if (req_rd) op = OP_READ;
    else             op = OP_NONE;

    in_cfg  = (page <= CFG_L);
    in_prg  = !in_cfg && (page <= PRG_L);
    prot_ok = in_cfg ? sec_c : (in_prg ? sec_p : 1'b1);
    aligned = (page[AB-1:0] == '0);

    unique case (op)
      OP_READ:  legal = 1'b1;
      OP_WRITE: legal = prot_ok;
      OP_ERASE: legal = prot_ok && aligned;
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpr_seq.sv
module fpr_seq
  import fpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd,
  input  fop_e       op,
  input  logic       legal,
  input  logic       eng_done,
  output logic       sec_p_eff,
  output logic       sec_c_eff,
  output logic       busy_q,
  output logic       err_q,
  output logic       start_q,
  output fop_e       op_q,
  output logic       pack_q
);
  logic busy_d, err_d, start_d, pack_d, secp_q, secc_q, secp_d, secc_d;
  fop_e op_d;
  logic acc;

  assign acc       = cmd_wr && !busy_q;
  assign sec_p_eff = secp_q || (acc && cmd[B_SECP]);
  assign sec_c_eff = secc_q || (acc && cmd[B_SECC]);

  always_comb begin
    busy_d  = busy_q;
    err_d   = err_q;
    start_d = 1'b0;
    pack_d  = pack_q;
    op_d    = op_q;
    secp_d  = secp_q;
    secc_d  = secc_q;
    if (acc) begin
      pack_d = cmd[B_PACK];
      secp_d = sec_p_eff;
      secc_d = sec_c_eff;
      if (op != OP_NONE) begin
        if (legal) begin
          busy_d  = 1'b1;
          start_d = 1'b1;
          op_d    = op;
          err_d   = 1'b0;
        end else begin
          err_d  = 1'b1;
          secp_d = 1'b0;
          secc_d = 1'b0;
        end
      end
    end
    if (busy_q && eng_done) begin
      busy_d = 1'b0;
      secp_d = 1'b0;
      secc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      pack_q  <= 1'b0;
      op_q    <= OP_NONE;
      secp_q  <= 1'b0;
      secc_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      err_q   <= err_d;
      start_q <= start_d;
      pack_q  <= pack_d;
      op_q    <= op_d;
      secp_q  <= secp_d;
      secc_q  <= secc_d;
    end
  end

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q);
  // R8
  err_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!busy_q && !start_q));
  // R10
  sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eng_done) |=> (!secp_q && !secc_q && !busy_q));
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eng_done) |=> (busy_q && $stable(op_q) && $stable(pack_q)));
endmodule

// File: rtl/flash_req_ctrl.sv
module flash_req_ctrl
  import fpr_pkg::*;
#(
  parameter int          PAGE_W       = 16,
  parameter int          OFFS_W       = 8,
  parameter int unsigned CFG_LAST     = 32'h02FF,
  parameter int unsigned PRG_LAST     = 32'h05FF,
  parameter int          SECTOR_PAGES = 16,
  localparam int         ADDR_W       = PAGE_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [PAGE_W-1:0] rd_data,
  output logic              eng_start,
  output logic [1:0]        eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              eng_len512,
  input  logic              eng_done
);
  localparam int SEC_AW = $clog2(SECTOR_PAGES);

  logic [1:0]        rs_q;
  logic              rst_s;
  logic [PAGE_W-1:0] page_q;
  logic              busy_q, err_q, sec_p, sec_c, legal, start_q, pack_q;
  fop_e              op, op_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  fpr_page_reg #(.PW(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_s),
    .load(wr_en && !wr_sel && !busy_q),
    .din(wr_data), .page_q(page_q)
  );

  fpr_guard #(
    .PW(PAGE_W), .CFG_LAST(CFG_LAST), .PRG_LAST(PRG_LAST),
    .SECTOR_PAGES(SECTOR_PAGES)
  ) u_guard (
    .page(page_q),
    .req_ers(wr_data[B_ERS]), .req_wr(wr_data[B_WR]), .req_rd(wr_data[B_RD]),
    .sec_p(sec_p), .sec_c(sec_c), .op(op), .legal(legal)
  );

  fpr_seq u_seq (
    .clk(clk), .rst_n(rst_s),
    .cmd_wr(wr_en && wr_sel), .cmd(wr_data[7:0]),
    .op(op), .legal(legal), .eng_done(eng_done),
    .sec_p_eff(sec_p), .sec_c_eff(sec_c),
    .busy_q(busy_q), .err_q(err_q), .start_q(start_q),
    .op_q(op_q), .pack_q(pack_q)
  );

  assign eng_start  = start_q;
  assign eng_op     = op_q;
  assign eng_addr   = {page_q, {OFFS_W{1'b0}}};
  assign eng_len512 = pack_q;
  assign rd_data    = rd_sel ? PAGE_W'({err_q, busy_q}) : page_q;

  // R11
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && $past(busy_q)) |-> $stable(eng_addr));
  // R7
  erase_align_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (eng_start && eng_op == OP_ERASE) |-> (eng_addr[OFFS_W+SEC_AW-1:0] == '0));
endmodule

// File: tb/sim_flash_req_ctrl.sv
module sim_flash_req_ctrl;
  localparam time TCLK = 10ns;

  typedef struct packed {
    logic [15:0] page;
    logic [7:0]  cmd;
    logic        ok;
    logic [1:0]  op;
    logic        len;
    logic [7:0]  rq;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{16'h0000, 8'h04, 1'b1, 2'd1, 1'b0, 8'd4},   // R4 read at page 0
    '{16'h0100, 8'h08, 1'b0, 2'd0, 1'b0, 8'd5},   // R5 no unlock
    '{16'h0100, 8'h48, 1'b1, 2'd2, 1'b0, 8'd5},   // R5 unlocked
    '{16'h0300, 8'h48, 1'b0, 2'd0, 1'b0, 8'd6},   // R6 wrong unlock
    '{16'h0300, 8'h88, 1'b1, 2'd2, 1'b0, 8'd6},   // R6 unlocked
    '{16'h05FF, 8'h90, 1'b0, 2'd0, 1'b0, 8'd7},   // R7 misaligned
    '{16'h05F0, 8'h90, 1'b1, 2'd3, 1'b0, 8'd7},   // R7 aligned
    '{16'h0600, 8'h08, 1'b1, 2'd2, 1'b0, 8'd6},   // R6 open space
    '{16'h0601, 8'h10, 1'b0, 2'd0, 1'b0, 8'd7},   // R7 misaligned open
    '{16'h02FF, 8'h88, 1'b0, 2'd0, 1'b0, 8'd5},   // R5 program bit does not count
    '{16'h0200, 8'h5C, 1'b1, 2'd3, 1'b0, 8'd3},   // R3 erase wins
    '{16'h0700, 8'h0C, 1'b1, 2'd2, 1'b0, 8'd3},   // R3 write beats read
    '{16'h1234, 8'h24, 1'b1, 2'd1, 1'b1, 8'd2},   // R2 packed length
    '{16'hFFFF, 8'hC4, 1'b1, 2'd1, 1'b0, 8'd4}    // R4 top page
  };

  logic        clk = 1'b0;
  logic        rst_n, wr_en, wr_sel, rd_sel, eng_done;
  logic [15:0] wr_data, rd_data;
  logic        eng_start, eng_len512;
  logic [1:0]  eng_op;
  logic [23:0] eng_addr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  flash_req_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr),
    .eng_len512(eng_len512), .eng_done(eng_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd_sel = 1'b1; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state, R1
    chk("R1 reset status", rd_data, 0);
    chk("R9 reset start", eng_start, 0);
    rd_sel = 1'b0; #1;
    chk("R1 reset page", rd_data, 0);
    rd_sel = 1'b1;

    for (int i = 0; i < 14; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      wr(1'b0, VECS[i].page);
      wr(1'b1, {8'h00, VECS[i].cmd});
      chk({t, " start"}, eng_start, VECS[i].ok);
      chk({t, " status"}, rd_data, VECS[i].ok ? 32'h1 : 32'h2);
      if (VECS[i].ok) begin
        chk({t, " op"}, eng_op, VECS[i].op);
        chk({t, " addr"}, eng_addr, {VECS[i].page, 8'h00});
        chk({t, " len"}, eng_len512, VECS[i].len);
      end
      @(negedge clk);
      chk({t, " pulse end"}, eng_start, 0);
      if (VECS[i].ok) begin
        done_pulse();
        chk({t, " done status"}, rd_data, 0);
      end
    end

    // R1: unlock and length bits without a request do not show in status
    wr(1'b1, 16'h00E0);
    chk("R1 status only busy and error", rd_data, 0);
    // R10: stored unlock carries to the next request, then clears
    wr(1'b0, 16'h0100);
    wr(1'b1, 16'h0008);
    chk("R10 stored unlock used", eng_start, 1);
    done_pulse();
    wr(1'b1, 16'h0008);
    chk("R10 unlock cleared after done", rd_data, 2);
    // R10: refusal clears unlock bits
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0088);
    chk("R10 refused", rd_data, 2);
    wr(1'b0, 16'h0300);
    wr(1'b1, 16'h0008);
    chk("R10 unlock cleared after refusal", eng_start, 0);
    chk("R8 error held", rd_data, 2);

    // R11: writes ignored while busy
    wr(1'b0, 16'h0800);
    wr(1'b1, 16'h0004);
    chk("R9 accept clears error", rd_data, 1);
    wr(1'b0, 16'h0900);
    chk("R11 addr held while busy", eng_addr, 24'h080000);
    wr(1'b1, 16'h0010);
    chk("R11 command ignored while busy", eng_start, 0);
    chk("R11 op unchanged", eng_op, 1);
    // R11: done and command write in the same cycle
    @(negedge clk);
    eng_done = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0004;
    @(negedge clk);
    eng_done = 1'b0; wr_en = 1'b0;
    chk("R11 same-cycle no start", eng_start, 0);
    chk("R11 same-cycle status", rd_data, 0);
    @(negedge clk);
    chk("R11 same-cycle still idle", eng_start, 0);
    rd_sel = 1'b0; #1;
    chk("R11 page unchanged", rd_data, 16'h0800);
    rd_sel = 1'b1;
    // R11: done while idle
    done_pulse();
    chk("R11 done idle", rd_data, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule